// File: doc/BRIEF.md
# Memory-Window I2C Target Sequencer

This block is the byte-level control layer of an I2C target that exposes two small byte memories. An external host accesses them the way it would access a serial EEPROM. A bit-level engine, which is not part of this block, detects the bus conditions and passes them in as single-cycle events: start, repeated start, stop, bus error, address match (which of two target addresses, and whether the host reads or writes), and each received byte. The sequencer answers every received byte with an accept/reject decision and every transmit request with a byte. It also signals once per finished transfer.

Each target address owns a RAM window with its own run-time size and write limit. Each window also keeps a remembered starting offset. A write transfer first carries a sub-address of one or two bytes, and that sub-address becomes the remembered offset. Any data bytes that follow are stored from that offset upward through a separate running pointer, so the remembered offset itself does not move. A read transfer always begins at the remembered offset and may run for any length. Once the pointer passes the window's end, the block returns filler bytes.

Top module: `eeprom_tgt_seq`

## Requirements
- R1: While reset is asserted and after it is released, ack_vld, tx_vld and done_vld are 0, and the remembered offsets of both windows are 0. A read that follows reset therefore starts at location 0, whatever offset was set before the reset.
- R2: When cfg_sub16 is 0, the first byte received after a write match is the sub-address. When cfg_sub16 is 1, the first two bytes form the sub-address, most significant byte first, and the first byte is always accepted.
- R3: If the complete sub-address is less than the selected window's size, it is accepted and becomes the remembered offset. Otherwise it is rejected (ack_ok=0), the remembered offset is unchanged, and the transfer ends.
- R4: Data bytes after an accepted sub-address are stored at consecutive locations starting at the sub-address. Each accepted byte advances the running pointer. The remembered offset is not altered by data bytes.
- R5: A data byte whose location is at or above the window's write limit, or at or above its size, is rejected (ack_ok=0) and not stored.
- R6: Every read transfer starts at the remembered offset. Two reads in a row return the same leading bytes, whatever the length of the first one.
- R7: Reads are unbounded. A byte at a location at or beyond the window size is returned as 8'hFF, and every later byte in that transfer is 8'hFF too.
- R8: A write that carries only the sub-address, followed by a repeated start and a read match, makes the read begin at the new sub-address.
- R9: match_sel=0 selects window A (size_a, bound_a) and match_sel=1 selects window B (size_b, bound_b). The two windows have separate storage and separate remembered offsets.
- R10: A stop, a repeated start or a bus error abandons the current transfer. After a stop or an error, received bytes are ignored (no ack_vld) until a start and a match. A 16-bit sub-address interrupted after its first byte does not change the remembered offset.
- R11: ack_vld pulses exactly one clock after each ev_rx that is accepted for processing. tx_vld pulses exactly one clock after each tx_req that arrives during a read.
- R12: When a transfer that passed its address match ends by stop, repeated start, start or error, done_vld pulses one clock later, with done_sel naming the window and done_rd=1 for a read. A write ended by a rejected sub-address produces no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sub16 | input | 1 | 1: two-byte sub-address, 0: one byte |
| size_a | input | IW | Window A size in bytes (at most DEPTH) |
| bound_a | input | IW | Window A write limit |
| size_b | input | IW | Window B size in bytes (at most DEPTH) |
| bound_b | input | IW | Window B write limit |
| ev_start | input | 1 | Start condition seen |
| ev_restart | input | 1 | Repeated start seen |
| ev_stop | input | 1 | Stop condition seen |
| ev_err | input | 1 | Bus error seen |
| ev_match | input | 1 | Own address matched |
| match_sel | input | 1 | Matched address: 0 window A, 1 window B |
| match_rd | input | 1 | Matched transfer direction: 1 read |
| ev_rx | input | 1 | A byte was received |
| rx_byte | input | 8 | Received byte |
| ack_vld | output | 1 | Accept/reject decision valid |
| ack_ok | output | 1 | 1 accept, 0 reject |
| tx_req | input | 1 | Engine requests the next byte to send |
| tx_vld | output | 1 | tx_byte valid |
| tx_byte | output | 8 | Byte to send |
| done_vld | output | 1 | A transfer has finished |
| done_sel | output | 1 | Window of the finished transfer |
| done_rd | output | 1 | Finished transfer was a read |

## Verification
The assertions check the following on every cycle:
- ack and transmit responses occur only one cycle after their triggering events;
- no RAM write reaches a location at or above the active window's limit or size;
- a remembered offset changes only in the cycle after a received byte, and only to a value inside the window;
- done pulses occur only after an ending condition.

Whether the stored and returned bytes are correct can only be shown by the bench's scenarios. The same holds for filler after the window end, for reads that keep restarting at the same offset, and for a broken 16-bit sub-address being discarded. The bench covers these with sweeps over every sub-address in both windows and both sub-address widths, compared against an arithmetic model.

// File: rtl/eeprom_tgt_pkg.sv
package eeprom_tgt_pkg;

  // Sequencer phases of a transfer.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_OFS_HI,
    ST_OFS_LO,
    ST_DATA0,
    ST_DATAN,
    ST_TX
  } seq_st_t;

  // Number of target addresses / memory windows.
  localparam int NBANK = 2;

  // Byte returned outside a window.
  localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/tgt_rst_sync.sv
module tgt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic meta_q;

  // Assert asynchronously, release on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end

endmodule

// File: rtl/tgt_bank.sv
module tgt_bank #(
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          base_ld,
  input  logic [IW-1:0] base_in,
  output logic [IW-1:0] base_q
);

  localparam int AW = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];

  // The sequencer only issues addresses below the window size (<= DEPTH),
  // so the top pointer bit is not needed for indexing.
  logic unused_hi;
  assign unused_hi = &{1'b0, wr_addr[IW-1], rd_addr[IW-1]};

  // Storage: no reset, write and registered read share the clock.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr[AW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr[AW-1:0]];
    end
  end

  // Remembered start offset of this window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_ld) begin
      base_q <= base_in;
    end
  end

endmodule

// File: rtl/tgt_seq.sv
module tgt_seq
  import eeprom_tgt_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_sub16,
  input  logic [NBANK-1:0][IW-1:0]   win_size,
  input  logic [NBANK-1:0][IW-1:0]   win_bound,
  input  logic [NBANK-1:0][IW-1:0]   win_base,
  input  logic [NBANK-1:0][7:0]      win_rdata,
  input  logic                       ev_start,
  input  logic                       ev_restart,
  input  logic                       ev_stop,
  input  logic                       ev_err,
  input  logic                       ev_match,
  input  logic                       match_sel,
  input  logic                       match_rd,
  input  logic                       ev_rx,
  input  logic [7:0]                 rx_byte,
  input  logic                       tx_req,
  output logic                       cur_sel,
  output logic                       mem_we,
  output logic                       mem_re,
  output logic [IW-1:0]              mem_addr,
  output logic                       base_ld,
  output logic [IW-1:0]              base_val,
  output logic                       ack_vld,
  output logic                       ack_ok,
  output logic                       tx_vld,
  output logic [7:0]                 tx_byte,
  output logic                       done_vld,
  output logic                       done_sel,
  output logic                       done_rd
);

  seq_st_t       st_q, st_d;
  logic          sel_q, sel_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [7:0]    hi_q, hi_d;
  logic          ack_vld_q, ack_vld_d;
  logic          ack_ok_q, ack_ok_d;
  logic          tx_vld_q, tx_vld_d;
  logic          pad_q, pad_d;
  logic          done_vld_q, done_vld_d;
  logic          done_sel_q, done_sel_d;
  logic          done_rd_q, done_rd_d;

  logic [IW-1:0] size_s;
  logic [IW-1:0] bound_s;
  logic [15:0]   ofs16;
  logic          ofs_fits;
  logic          idx_in_win;
  logic          idx_writable;
  logic          in_xfer;
  logic          ev_end;
  logic          ev_begin;

  assign size_s       = win_size[sel_q];
  assign bound_s      = win_bound[sel_q];
  assign ofs16        = {hi_q, rx_byte};
  assign ofs_fits     = ofs16 < 16'(size_s);
  assign idx_in_win   = idx_q < size_s;
  assign idx_writable = idx_in_win && (idx_q < bound_s);
  assign in_xfer      = (st_q == ST_OFS_HI) || (st_q == ST_OFS_LO) ||
                        (st_q == ST_DATA0)  || (st_q == ST_DATAN)  ||
                        (st_q == ST_TX);
  assign ev_end       = ev_stop | ev_err;
  assign ev_begin     = ev_start | ev_restart;

  // Next-state logic.
  always_comb begin
    st_d       = st_q;
    sel_d      = sel_q;
    idx_d      = idx_q;
    hi_d       = hi_q;
    ack_vld_d  = 1'b0;
    ack_ok_d   = 1'b0;
    tx_vld_d   = 1'b0;
    pad_d      = pad_q;
    done_vld_d = 1'b0;
    done_sel_d = done_sel_q;
    done_rd_d  = done_rd_q;
    mem_we     = 1'b0;
    mem_re     = 1'b0;
    base_ld    = 1'b0;
    base_val   = ofs16[IW-1:0];

    if (ev_end || ev_begin) begin
      // Any bus condition closes the current transfer.
      if (in_xfer) begin
        done_vld_d = 1'b1;
        done_sel_d = sel_q;
        done_rd_d  = (st_q == ST_TX);
      end
      st_d = ev_end ? ST_IDLE : ST_ADDR;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d = ST_IDLE;
        end
        ST_ADDR: begin
          if (ev_match) begin
            sel_d = match_sel;
            hi_d  = 8'h00;
            if (match_rd) begin
              st_d  = ST_TX;
              idx_d = win_base[match_sel];
            end else begin
              st_d = cfg_sub16 ? ST_OFS_HI : ST_OFS_LO;
            end
          end
        end
        ST_OFS_HI: begin
          if (ev_rx) begin
            hi_d      = rx_byte;
            ack_vld_d = 1'b1;
            ack_ok_d  = 1'b1;
            st_d      = ST_OFS_LO;
          end
        end
        ST_OFS_LO: begin
          if (ev_rx) begin
            ack_vld_d = 1'b1;
            if (ofs_fits) begin
              ack_ok_d = 1'b1;
              base_ld  = 1'b1;
              idx_d    = ofs16[IW-1:0];
              st_d     = ST_DATA0;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_DATA0, ST_DATAN: begin
          if (ev_rx) begin
            ack_vld_d = 1'b1;
            if (idx_writable) begin
              mem_we   = 1'b1;
              ack_ok_d = 1'b1;
              idx_d    = IW'(idx_q + 1'b1);
              st_d     = ST_DATAN;
            end
          end
        end
        ST_TX: begin
          if (tx_req) begin
            mem_re   = idx_in_win;
            tx_vld_d = 1'b1;
            pad_d    = !idx_in_win;
            if (idx_in_win) begin
              idx_d = IW'(idx_q + 1'b1);
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sel_q      <= 1'b0;
      idx_q      <= '0;
      hi_q       <= 8'h00;
      ack_vld_q  <= 1'b0;
      ack_ok_q   <= 1'b0;
      tx_vld_q   <= 1'b0;
      pad_q      <= 1'b0;
      done_vld_q <= 1'b0;
      done_sel_q <= 1'b0;
      done_rd_q  <= 1'b0;
    end else begin
      st_q       <= st_d;
      sel_q      <= sel_d;
      idx_q      <= idx_d;
      hi_q       <= hi_d;
      ack_vld_q  <= ack_vld_d;
      ack_ok_q   <= ack_ok_d;
      tx_vld_q   <= tx_vld_d;
      pad_q      <= pad_d;
      done_vld_q <= done_vld_d;
      done_sel_q <= done_sel_d;
      done_rd_q  <= done_rd_d;
    end
  end

  assign cur_sel  = sel_q;
  assign mem_addr = idx_q;
  assign ack_vld  = ack_vld_q;
  assign ack_ok   = ack_ok_q;
  assign tx_vld   = tx_vld_q;
  assign tx_byte  = pad_q ? FILL_BYTE : win_rdata[sel_q];
  assign done_vld = done_vld_q;
  assign done_sel = done_sel_q;
  assign done_rd  = done_rd_q;

endmodule

// File: rtl/eeprom_tgt_seq.sv
module eeprom_tgt_seq
  import eeprom_tgt_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int IW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sub16,
  input  logic [IW-1:0] size_a,
  input  logic [IW-1:0] bound_a,
  input  logic [IW-1:0] size_b,
  input  logic [IW-1:0] bound_b,
  input  logic          ev_start,
  input  logic          ev_restart,
  input  logic          ev_stop,
  input  logic          ev_err,
  input  logic          ev_match,
  input  logic          match_sel,
  input  logic          match_rd,
  input  logic          ev_rx,
  input  logic [7:0]    rx_byte,
  output logic          ack_vld,
  output logic          ack_ok,
  input  logic          tx_req,
  output logic          tx_vld,
  output logic [7:0]    tx_byte,
  output logic          done_vld,
  output logic          done_sel,
  output logic          done_rd
);

  logic                     rst_q;
  logic [NBANK-1:0][IW-1:0] win_size;
  logic [NBANK-1:0][IW-1:0] win_bound;
  logic [NBANK-1:0][IW-1:0] bank_base;
  logic [NBANK-1:0][7:0]    bank_rdata;
  logic                     cur_sel;
  logic                     mem_we;
  logic                     mem_re;
  logic [IW-1:0]            mem_addr;
  logic                     base_ld;
  logic [IW-1:0]            base_val;

  assign win_size[0]  = size_a;
  assign win_size[1]  = size_b;
  assign win_bound[0] = bound_a;
  assign win_bound[1] = bound_b;

  tgt_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  tgt_seq #(.IW(IW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_q),
    .cfg_sub16  (cfg_sub16),
    .win_size   (win_size),
    .win_bound  (win_bound),
    .win_base   (bank_base),
    .win_rdata  (bank_rdata),
    .ev_start   (ev_start),
    .ev_restart (ev_restart),
    .ev_stop    (ev_stop),
    .ev_err     (ev_err),
    .ev_match   (ev_match),
    .match_sel  (match_sel),
    .match_rd   (match_rd),
    .ev_rx      (ev_rx),
    .rx_byte    (rx_byte),
    .tx_req     (tx_req),
    .cur_sel    (cur_sel),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr),
    .base_ld    (base_ld),
    .base_val   (base_val),
    .ack_vld    (ack_vld),
    .ack_ok     (ack_ok),
    .tx_vld     (tx_vld),
    .tx_byte    (tx_byte),
    .done_vld   (done_vld),
    .done_sel   (done_sel),
    .done_rd    (done_rd)
  );

  // One storage window per target address.
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit;
    assign hit = (cur_sel == 1'(g));

    tgt_bank #(.DEPTH(DEPTH), .IW(IW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_q),
      .wr_en   (mem_we && hit),
      .wr_addr (mem_addr),
      .wr_data (rx_byte),
      .rd_en   (mem_re && hit),
      .rd_addr (mem_addr),
      .rd_data (bank_rdata[g]),
      .base_ld (base_ld && hit),
      .base_in (base_val),
      .base_q  (bank_base[g])
    );
  end

endmodule

// File: rtl/eeprom_tgt_seq_chk.sv
module eeprom_tgt_seq_chk #(
  parameter int IW = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [IW-1:0]      size_a,
  input logic [IW-1:0]      bound_a,
  input logic [IW-1:0]      size_b,
  input logic [IW-1:0]      bound_b,
  input logic               ev_start,
  input logic               ev_restart,
  input logic               ev_stop,
  input logic               ev_err,
  input logic               ev_rx,
  input logic               tx_req,
  input logic               ack_vld,
  input logic               tx_vld,
  input logic               done_vld,
  input logic               cur_sel,
  input logic               mem_we,
  input logic [IW-1:0]      mem_addr,
  input logic               base_ld,
  input logic [IW-1:0]      base_val,
  input logic [1:0][IW-1:0] bank_base
);

  logic [IW-1:0] lim_sel;
  logic [IW-1:0] sz_sel;
  assign lim_sel = cur_sel ? bound_b : bound_a;
  assign sz_sel  = cur_sel ? size_b : size_a;

  a_r11_ack_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(ev_rx));

  a_r11_tx_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> $past(tx_req));

  a_r5_write_inside_limit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr < lim_sel) && (mem_addr < sz_sel));

  a_r3_base_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    base_ld |-> (base_val < sz_sel));

  a_r4_base_a_moves_on_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_base[0] != $past(bank_base[0])) |-> $past(ev_rx));

  a_r4_base_b_moves_on_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_base[1] != $past(bank_base[1])) |-> $past(ev_rx));

  a_r12_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> $past(ev_stop | ev_err | ev_restart | ev_start));

endmodule

bind eeprom_tgt_seq eeprom_tgt_seq_chk #(.IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .size_a     (size_a),
  .bound_a    (bound_a),
  .size_b     (size_b),
  .bound_b    (bound_b),
  .ev_start   (ev_start),
  .ev_restart (ev_restart),
  .ev_stop    (ev_stop),
  .ev_err     (ev_err),
  .ev_rx      (ev_rx),
  .tx_req     (tx_req),
  .ack_vld    (ack_vld),
  .tx_vld     (tx_vld),
  .done_vld   (done_vld),
  .cur_sel    (cur_sel),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .base_ld    (base_ld),
  .base_val   (base_val),
  .bank_base  (bank_base)
);

// File: tb/sim_eeprom_tgt_seq.sv
module sim_eeprom_tgt_seq;

  localparam int DEPTH = 16;
  localparam int IW    = $clog2(DEPTH) + 1;

  logic          clk;
  logic          rst_n;
  logic          cfg_sub16;
  logic [IW-1:0] size_a, bound_a, size_b, bound_b;
  logic          ev_start, ev_restart, ev_stop, ev_err;
  logic          ev_match, match_sel, match_rd;
  logic          ev_rx;
  logic [7:0]    rx_byte;
  logic          ack_vld, ack_ok;
  logic          tx_req, tx_vld;
  logic [7:0]    tx_byte;
  logic          done_vld, done_sel, done_rd;

  int total = 0;
  int bad   = 0;

  // Bench model of both windows.
  int mm [2][DEPTH];
  int bm [2];
  int sz [2];
  int bd [2];

  eeprom_tgt_seq #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_sub16(cfg_sub16),
    .size_a(size_a), .bound_a(bound_a), .size_b(size_b), .bound_b(bound_b),
    .ev_start(ev_start), .ev_restart(ev_restart), .ev_stop(ev_stop),
    .ev_err(ev_err), .ev_match(ev_match), .match_sel(match_sel),
    .match_rd(match_rd), .ev_rx(ev_rx), .rx_byte(rx_byte),
    .ack_vld(ack_vld), .ack_ok(ack_ok), .tx_req(tx_req), .tx_vld(tx_vld),
    .tx_byte(tx_byte), .done_vld(done_vld), .done_sel(done_sel),
    .done_rd(done_rd)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic p_start();
    ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
  endtask

  task automatic p_match(input int s, input bit rd);
    match_sel = s[0]; match_rd = rd; ev_match = 1'b1;
    @(negedge clk); ev_match = 1'b0;
  endtask

  // End a transfer and check the completion report (R12).
  task automatic p_end(input int kind, input bit exp_done, input int s, input bit rd);
    if (kind == 0) ev_stop = 1'b1;
    else if (kind == 1) ev_restart = 1'b1;
    else ev_err = 1'b1;
    @(negedge clk);
    ev_stop = 1'b0; ev_restart = 1'b0; ev_err = 1'b0;
    chk(done_vld === exp_done, "R12 done pulse", int'(done_vld), int'(exp_done));
    if (exp_done) begin
      chk(done_sel === s[0] && done_rd === rd, "R12 done fields",
          int'({done_sel, done_rd}), int'({s[0], rd}));
    end
  endtask

  task automatic p_rx(input int b, input bit exp_ok, input string rq);
    rx_byte = b[7:0]; ev_rx = 1'b1;
    @(negedge clk); ev_rx = 1'b0;
    chk(ack_vld === 1'b1 && ack_ok === exp_ok, rq,
        int'({ack_vld, ack_ok}), int'({1'b1, exp_ok}));
  endtask

  task automatic p_rx_ignored(input string rq);
    rx_byte = 8'h5A; ev_rx = 1'b1;
    @(negedge clk); ev_rx = 1'b0;
    chk(ack_vld === 1'b0, rq, int'(ack_vld), 0);
  endtask

  task automatic p_tx(input int exp, input string rq);
    tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    chk(tx_vld === 1'b1 && int'(tx_byte) == exp, rq, int'(tx_byte), exp);
  endtask

  // Full write transfer against the model.
  task automatic do_write(input int s, input int ofs, input bit sub16, input int n, input int seed);
    int idx;
    bit ok;
    cfg_sub16 = sub16;
    p_start();
    p_match(s, 1'b0);
    if (sub16) p_rx(ofs >> 8, 1'b1, "R2 high sub-address byte");
    ok = ofs < sz[s];
    p_rx(ofs & 255, ok, ok ? "R2 sub-address accepted" : "R3 sub-address rejected");
    if (ok) begin
      bm[s] = ofs;
      idx = ofs;
      for (int k = 0; k < n; k++) begin
        int d;
        bit a;
        d = (seed + k * 37 + s * 101) & 255;
        a = (idx < bd[s]) && (idx < sz[s]);
        p_rx(d, a, a ? "R4 data stored" : "R5 data past limit");
        if (a) begin
          mm[s][idx] = d;
          idx++;
        end
      end
    end
    p_end(0, ok, s, 1'b0);
  endtask

  // Full read transfer against the model.
  task automatic do_read(input int s, input int n, input string rq);
    int idx;
    p_start();
    p_match(s, 1'b1);
    idx = bm[s];
    for (int k = 0; k < n; k++) begin
      if (idx < sz[s]) begin
        p_tx(mm[s][idx], rq);
        idx++;
      end else begin
        p_tx(255, "R7 filler past end");
      end
    end
    p_end(0, 1'b1, s, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_sub16 = 1'b0;
    ev_start = 1'b0; ev_restart = 1'b0; ev_stop = 1'b0; ev_err = 1'b0;
    ev_match = 1'b0; match_sel = 1'b0; match_rd = 1'b0;
    ev_rx = 1'b0; rx_byte = 8'h00; tx_req = 1'b0;
    sz[0] = 12; bd[0] = 8; sz[1] = 10; bd[1] = 10;
    size_a = IW'(sz[0]); bound_a = IW'(bd[0]);
    size_b = IW'(sz[1]); bound_b = IW'(bd[1]);
    bm[0] = 0; bm[1] = 0;
    repeat (3) @(negedge clk);
    chk(ack_vld === 1'b0 && tx_vld === 1'b0 && done_vld === 1'b0,
        "R1 outputs in reset", int'({ack_vld, tx_vld, done_vld}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ack_vld === 1'b0 && tx_vld === 1'b0 && done_vld === 1'b0,
        "R1 outputs after reset", int'({ack_vld, tx_vld, done_vld}), 0);

    // Fill both windows completely (within limits) from offset 0.
    do_write(0, 0, 1'b0, 12, 3);
    do_write(1, 0, 1'b0, 10, 9);

    // R1: base set to 3, then reset brings it back to 0.
    do_write(0, 3, 1'b0, 0, 0);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bm[0] = 0; bm[1] = 0;
    do_read(0, 2, "R1 read starts at 0 after reset");

    // Sweep every sub-address of window A, 8-bit and 16-bit modes.
    for (int o = 0; o < DEPTH; o++) begin
      do_write(0, o, 1'b0, 3, o * 11);
      do_read(0, 5, "R6 read from base A");
      do_read(0, 2, "R6 repeated read same start");
    end
    for (int o = 0; o < DEPTH; o++) begin
      do_write(0, o, 1'b1, 2, o * 5 + 1);
      do_read(0, 4, "R2 16-bit base read A");
    end
    // R3: high sub-address byte non-zero is out of range.
    do_write(0, 256 + 2, 1'b1, 1, 7);
    do_read(0, 2, "R3 base kept after reject");

    // Window B, 16-bit mode sweep; window A must stay unaffected (R9).
    for (int o = 0; o < DEPTH; o++) begin
      do_write(1, o, 1'b1, 4, o * 13 + 2);
      do_read(1, 3, "R9 read from base B");
    end
    do_read(0, 3, "R9 window A untouched by B");

    // R7: long read runs off the end.
    do_write(1, 7, 1'b0, 0, 0);
    do_read(1, 8, "R7 bytes before end");

    // R8: sub-address only, repeated start, read.
    cfg_sub16 = 1'b0;
    p_start(); p_match(0, 1'b0);
    p_rx(5, 1'b1, "R8 sub-address only");
    bm[0] = 5;
    p_end(1, 1'b1, 0, 1'b0);
    p_match(0, 1'b1);
    for (int k = 0; k < 3; k++) p_tx(mm[0][5 + k], "R8 read from new base");
    p_end(0, 1'b1, 0, 1'b1);

    // R10: broken 16-bit sub-address leaves the base at 5.
    cfg_sub16 = 1'b1;
    p_start(); p_match(0, 1'b0);
    p_rx(0, 1'b1, "R10 high byte before abort");
    p_end(1, 1'b1, 0, 1'b0);
    p_match(0, 1'b1);
    p_tx(mm[0][5], "R10 base kept after partial sub-address");
    p_end(2, 1'b1, 0, 1'b1);
    p_rx_ignored("R10 byte ignored after error");
    p_start(); p_match(1, 1'b0);
    p_end(0, 1'b1, 1, 1'b0);
    p_rx_ignored("R10 byte ignored after stop");
    cfg_sub16 = 1'b0;
    do_read(0, 1, "R10 base still 5");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule